// File: doc/BRIEF.md
# CPU Hotplug Register Controller

This block keeps the hotplug state of a fixed set of CPU slots and presents it to firmware through a small byte-addressed register window. Each slot carries a present flag, an insert-pending flag and a remove-pending flag. External logic raises per-slot insert and remove strobes. A single interrupt line tells the host that some slot needs attention.

After reset the window works in a legacy form. Offset 0x0 reads back a present bitmap with one bit per slot, and the boot slot's bit is always set. Firmware moves the block into its modern form by writing zero to offset 0x0. In modern form a DWORD selector picks one slot. A status/control byte reports that slot's flags and clears them. A command byte and a DWORD data port run commands. Command 0 searches for the next slot with a pending event and selects it. Commands 1 and 2 store the next data-port write into two readback registers that record the outcome of an event.

Top module: `cpu_hp_regs`

## Requirements
- R1: After reset the block is in legacy mode, a read of offset 0x0 returns only bit 0 set (slot 0 is present at reset), and `irq` is low.
- R2: In legacy mode, a read of offset 0x0 returns the present flags with bit k for slot k, and bit 0 always reads 1. All other offsets read zero.
- R3: In legacy mode, a nonzero write to 0x0 and any write to another offset change neither the bitmap nor the mode. A zero write to 0x0 switches to modern mode with the selector at 0. The block never returns to legacy mode except through reset.
- R4: In modern mode, a read of 0x0 returns the selector. A read of 0x4 returns the selected slot's flags: bit 0 present, bit 1 insert pending, bit 2 remove pending, all other bits zero.
- R5: While the selector is NUM_SLOTS or larger, writes to 0x4, 0x5 and 0x8 are ignored, and reads of 0x4 and 0x8 return zero. Writing a valid value to 0x0 restores normal access.
- R6: A write to 0x4 acts on the selected slot only. Bit 1 = 1 clears insert pending, bit 2 = 1 clears remove pending, bit 3 = 1 ejects (clears present), and bit 0 is ignored. A strobe in the same cycle as a clear wins.
- R7: Writing command 0 to offset 0x5 scans the slots upward from the selector, starting with the selected slot and wrapping past the last slot. It selects the first slot with either pending flag set, and the new selection is readable from the next cycle.
- R8: If command 0 finds no pending slot, the selector is unchanged.
- R9: A read of 0x8 returns the selector when the last command written was 0, and zero otherwise. Offset 0xC always reads zero in modern mode.
- R10: After command 1, a write to 0x8 stores its value in the event register, which reads back at 0x10. After command 2, a write to 0x8 stores its value in the status register, which reads back at 0x14. After any other nonzero command, a write to 0x8 changes neither register.
- R11: `irq` is high from the edge after an insert or remove strobe for as long as any slot has a pending flag set, and low once all pending flags are clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one cycle |
| addr | input | ADDR_W | Byte offset into the register window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| ins_stb | input | NUM_SLOTS | Per-slot insert request strobes |
| rem_stb | input | NUM_SLOTS | Per-slot remove request strobes |
| irq | output | 1 | High while any slot has an event pending |

## Verification
Read data follows the address in the same cycle. Every write and strobe takes effect at the rising edge that accepts it. This holds for a mode switch, a selector move found by a search, a flag clear, and an update of the event or status register, so the new value is readable right after that edge, and `irq` follows a strobe after that same single edge. The bench changes inputs only at falling edges and reads results before the next rising edge. Each check therefore observes the state exactly one edge after its stimulus. The vector table runs an ordered scenario in which each read depends on the writes before it. The directed tests cover the interrupt, the case where a clear and a strobe collide, and reset in the middle of a run.

// File: rtl/cpu_hp_regs.sv
module cpu_hp_regs #(
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  input  logic [NUM_SLOTS-1:0] ins_stb,
  input  logic [NUM_SLOTS-1:0] rem_stb,
  output logic                 irq
);

  localparam int IDX_W = $clog2(NUM_SLOTS);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_DLO = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_OEV = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_OST = ADDR_W'(20);
  localparam logic [IDX_W:0]    N_EXT = (IDX_W+1)'(NUM_SLOTS);

  logic                 legacy;
  logic [DATA_W-1:0]    sel;
  logic [NUM_SLOTS-1:0] present, ins_p, rem_p;
  logic [7:0]           last_cmd;
  logic [DATA_W-1:0]    ost_ev, ost_st;

  wire                 sel_ok = sel < DATA_W'(NUM_SLOTS);
  wire [IDX_W-1:0]     cur    = sel[IDX_W-1:0];
  wire                 mw     = wr_en && !legacy && sel_ok;
  wire                 wr_sel = wr_en && addr == A_SEL;
  wire                 wr_ctl = mw && addr == A_CTL;
  wire                 wr_cmd = mw && addr == A_CMD;
  wire                 wr_dat = mw && addr == A_DLO;
  wire                 cmd0   = wr_cmd && wdata[7:0] == 8'd0;
  wire [NUM_SLOTS-1:0] pend   = ins_p | rem_p;
  wire [NUM_SLOTS-1:0] hit_m  = wr_ctl ? (NUM_SLOTS'(1) << cur) : '0;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  always_comb begin
    logic [IDX_W:0] idx;
    hit     = 1'b0;
    hit_idx = cur;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      idx = {1'b0, cur} + (IDX_W+1)'(k);
      if (idx >= N_EXT) idx = idx - N_EXT;
      if (!hit && pend[idx[IDX_W-1:0]]) begin
        hit     = 1'b1;
        hit_idx = idx[IDX_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      legacy   <= 1'b1;
      sel      <= '0;
      last_cmd <= '0;
      ost_ev   <= '0;
      ost_st   <= '0;
    end else if (legacy) begin
      if (wr_sel && wdata == '0) begin
        legacy <= 1'b0;
        sel    <= '0;
      end
    end else begin
      if (wr_sel)
        sel <= wdata;
      else if (cmd0 && hit)
        sel <= DATA_W'(hit_idx);
      if (wr_cmd)
        last_cmd <= wdata[7:0];
      if (wr_dat && last_cmd == 8'd1)
        ost_ev <= wdata;
      if (wr_dat && last_cmd == 8'd2)
        ost_st <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= NUM_SLOTS'(1);
      ins_p   <= '0;
      rem_p   <= '0;
    end else begin
      present <= (present & ~(hit_m & {NUM_SLOTS{wdata[3]}})) | ins_stb;
      ins_p   <= (ins_p   & ~(hit_m & {NUM_SLOTS{wdata[1]}})) | ins_stb;
      rem_p   <= (rem_p   & ~(hit_m & {NUM_SLOTS{wdata[2]}})) | rem_stb;
    end
  end

  always_comb begin
    rdata = '0;
    if (legacy) begin
      if (addr == A_SEL) rdata = DATA_W'(present) | DATA_W'(1);
    end else begin
      case (addr)
        A_SEL: rdata = sel;
        A_CTL: if (sel_ok) rdata = DATA_W'({rem_p[cur], ins_p[cur], present[cur]});
        A_DLO: if (sel_ok && last_cmd == 8'd0) rdata = sel;
        A_OEV: rdata = ost_ev;
        A_OST: rdata = ost_st;
        default: rdata = '0;
      endcase
    end
  end

  assign irq = |pend;

  // R3
  legacy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && wr_en && addr == A_SEL && wdata != '0) |=> legacy);

  // R3
  mode_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !legacy |=> !legacy);

  // R5
  bad_sel_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!legacy && !sel_ok && wr_en && addr == A_CTL && ins_stb == '0 && rem_stb == '0)
      |=> ($stable(present) && $stable(ins_p) && $stable(rem_p)));

  // R7
  search_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0 && pend != '0) |=> (ins_p[cur] || rem_p[cur]));

  // R8
  search_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd0 && pend == '0) |=> $stable(sel));

  // R11
  strobe_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stb != '0 || rem_stb != '0) |=> irq);

endmodule

// File: tb/cpu_hp_regs_tb_top.sv
module cpu_hp_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 5;
  localparam int DW = 32;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_I = 2'd2, OP_M = 2'd3;
  localparam int NV = 52;

  // {op, addr, wdata, expected, requirement}
  localparam logic [74:0] VEC [NV] = '{
    {OP_R, 5'h00, 32'h0,    32'h1,    4'd1},  // R1
    {OP_I, 5'h00, 32'h08,   32'h0,    4'd2},
    {OP_R, 5'h00, 32'h0,    32'h09,   4'd2},  // R2
    {OP_W, 5'h00, 32'h55,   32'h0,    4'd3},
    {OP_R, 5'h00, 32'h0,    32'h09,   4'd3},  // R3
    {OP_W, 5'h04, 32'hFF,   32'h0,    4'd3},
    {OP_R, 5'h00, 32'h0,    32'h09,   4'd3},
    {OP_W, 5'h00, 32'h0,    32'h0,    4'd3},
    {OP_R, 5'h00, 32'h0,    32'h0,    4'd4},  // R4
    {OP_W, 5'h05, 32'h0,    32'h0,    4'd7},
    {OP_R, 5'h00, 32'h0,    32'h3,    4'd7},  // R7
    {OP_R, 5'h08, 32'h0,    32'h3,    4'd9},  // R9
    {OP_R, 5'h04, 32'h0,    32'h3,    4'd4},
    {OP_R, 5'h0C, 32'h0,    32'h0,    4'd9},
    {OP_W, 5'h04, 32'h02,   32'h0,    4'd6},
    {OP_R, 5'h04, 32'h0,    32'h1,    4'd6},  // R6
    {OP_W, 5'h05, 32'h0,    32'h0,    4'd8},
    {OP_R, 5'h00, 32'h0,    32'h3,    4'd8},  // R8
    {OP_I, 5'h00, 32'h02,   32'h0,    4'd7},
    {OP_M, 5'h00, 32'h20,   32'h0,    4'd7},
    {OP_W, 5'h05, 32'h0,    32'h0,    4'd7},
    {OP_R, 5'h00, 32'h0,    32'h5,    4'd7},
    {OP_R, 5'h04, 32'h0,    32'h4,    4'd4},
    {OP_W, 5'h04, 32'h04,   32'h0,    4'd6},
    {OP_W, 5'h05, 32'h0,    32'h0,    4'd7},
    {OP_R, 5'h00, 32'h0,    32'h1,    4'd7},  // wrap
    {OP_R, 5'h04, 32'h0,    32'h3,    4'd4},
    {OP_W, 5'h04, 32'h0B,   32'h0,    4'd6},
    {OP_R, 5'h04, 32'h0,    32'h0,    4'd6},
    {OP_W, 5'h05, 32'h1,    32'h0,    4'd10},
    {OP_W, 5'h08, 32'hABCD, 32'h0,    4'd10},
    {OP_R, 5'h10, 32'h0,    32'hABCD, 4'd10}, // R10
    {OP_R, 5'h08, 32'h0,    32'h0,    4'd9},
    {OP_W, 5'h05, 32'h2,    32'h0,    4'd10},
    {OP_W, 5'h08, 32'h1234, 32'h0,    4'd10},
    {OP_R, 5'h14, 32'h0,    32'h1234, 4'd10},
    {OP_R, 5'h10, 32'h0,    32'hABCD, 4'd10},
    {OP_W, 5'h05, 32'h3,    32'h0,    4'd10},
    {OP_W, 5'h08, 32'h5555, 32'h0,    4'd10},
    {OP_R, 5'h10, 32'h0,    32'hABCD, 4'd10},
    {OP_R, 5'h14, 32'h0,    32'h1234, 4'd10},
    {OP_W, 5'h05, 32'h0,    32'h0,    4'd8},
    {OP_R, 5'h08, 32'h0,    32'h1,    4'd9},
    {OP_I, 5'h00, 32'h04,   32'h0,    4'd5},
    {OP_W, 5'h00, 32'h9,    32'h0,    4'd5},
    {OP_W, 5'h04, 32'h0A,   32'h0,    4'd5},
    {OP_W, 5'h05, 32'h0,    32'h0,    4'd5},
    {OP_R, 5'h00, 32'h0,    32'h9,    4'd5},  // R5
    {OP_R, 5'h08, 32'h0,    32'h0,    4'd5},
    {OP_R, 5'h04, 32'h0,    32'h0,    4'd5},
    {OP_W, 5'h00, 32'h2,    32'h0,    4'd5},
    {OP_R, 5'h04, 32'h0,    32'h3,    4'd5}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  ins_stb = '0;
  logic [N-1:0]  rem_stb = '0;
  logic          irq;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  cpu_hp_regs #(.NUM_SLOTS(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ins_stb(ins_stb), .rem_stb(rem_stb), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req, input logic [DW-1:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  task automatic strobe(input logic [N-1:0] im, input logic [N-1:0] rm);
    @(negedge clk);
    ins_stb = im; rem_stb = rm;
    @(negedge clk);
    ins_stb = '0; rem_stb = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #2;
    check("R1 irq in reset", {31'b0, irq}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      logic [74:0] v;
      v = VEC[i];
      case (v[74:73])
        OP_W: wr(v[72:68], v[67:36]);
        OP_I: strobe(v[67:36][N-1:0], '0);
        OP_M: strobe('0, v[67:36][N-1:0]);
        default: rd(v[72:68], $sformatf("R%0d vec %0d", v[3:0], i), v[35:4]);
      endcase
    end
    // R11: slot 2 insert pending, selector at 2
    check("R11 irq pending", {31'b0, irq}, 32'h1);
    wr(5'h04, 32'h02);
    #1 check("R11 irq cleared", {31'b0, irq}, 32'h0);
    strobe('0, 8'h40);
    #1 check("R11 irq after strobe", {31'b0, irq}, 32'h1);
    // R6: clear collides with a new strobe on slot 6
    wr(5'h00, 32'h6);
    @(negedge clk);
    addr = 5'h04; wdata = 32'h04; wr_en = 1'b1; rem_stb = 8'h40;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0; rem_stb = '0;
    rd(5'h04, "R6 strobe beats clear", 32'h4);
    // R9: high data word
    rd(5'h0C, "R9 high word", 32'h0);
    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    rd(5'h00, "R1 legacy bitmap after reset", 32'h1);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: legacy mode reads of other offsets are zero
    rd(5'h04, "R2 legacy other offset", 32'h0);
    strobe(8'h81, '0);
    rd(5'h00, "R2 legacy bitmap", 32'h81);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule